// File: doc/BRIEF.md
# Halting MIPS-Subset Execution Core

This block runs a reduced 32-bit MIPS I integer program at one instruction per clock. In each cycle it fetches the word at the program counter, tests that word for one of two stop patterns, runs the ALU and next-PC logic, and then does at most one access to data memory. Instruction and data memories sit outside the core. The instruction port is read combinationally and addressed in bytes. The data port is addressed in words, with a combinational read and a write on the clock edge.

When a stop pattern is fetched, the core sets an internal halt flag that stays set until reset. From that cycle on, no register, memory or program-counter update takes effect, even though the clock keeps running. The `done` output does not show the flag at once. It samples the flag only on the edge that closes each window of C cycles, where C comes from an input. A host that polls `done` can therefore see up to C-1 extra cycles, and none of them has any effect.

Top module: `haltCore`

## Requirements
- R1: Instruction fields are op=[31:26], rs=[25:21], rt=[20:16], rd=[15:11], shamt=[10:6], funct=[5:0], imm=[15:0]. R-type ADDU (funct 0x21), SUBU (0x23), AND (0x24), OR (0x25), XOR (0x26) and NOR (0x27) write rd. ADDIU (op 0x09) uses a sign-extended imm. ANDI (0x0C), ORI (0x0D) and XORI (0x0E) use a zero-extended imm. LUI (0x0F) writes {imm,16'h0}. All I-type results go to rt.
- R2: SLL (funct 0x00), SRL (0x02) and SRA (0x03) shift the rt value by shamt and write rd. SRA fills with the sign bit.
- R3: SLT (funct 0x2A) compares signed. SLTU (funct 0x2B) and SLTIU (op 0x0B, sign-extended imm) compare unsigned. Each writes 1 or 0.
- R4: A non-branching instruction sets PC to PC+4. A taken BEQ (op 0x04), BNE (0x05), BLEZ (0x06, rs<=0 signed) or BGTZ (0x07, rs>0 signed) sets PC to PC+4+4*sign_extend(imm). An untaken branch sets PC to PC+4.
- R5: J (op 0x02) and JAL (0x03) jump to {PC+4[31:28], instr[25:0], 2'b00}. JAL writes PC+4 into register 31; there is no delay slot. JR (funct 0x08) jumps to the rs value.
- R6: LW (op 0x23) and SW (op 0x2B) use byte address rs+sign_extend(imm) and drive bits [31:2] of it on `memAddr`. LW writes `memRdData` into rt in the same cycle. SW raises `memWe` for one cycle with the rt value on `memWrData`. No other instruction writes memory.
- R7: Register 0 reads as zero and writes to it are discarded.
- R8: The core halts when the fetched word is 0x1000FFFF (BEQ $0,$0,-1), or when it is 0x03E00008 (JR $31) while register 31 holds zero. The halting instruction itself commits nothing. A JR $31 with register 31 nonzero is an ordinary return.
- R9: The halt flag is sticky until reset. While it is set, PC stays fixed, `memWe` stays low, and no register changes.
- R10: Clock edges are counted from reset release, starting at 1. `done` changes only on edges whose number is a multiple of C = `cfgInterval`; a value of 0 acts as 1. On each such edge, `done` takes the value the halt flag held just before that edge.
- R11: Opcodes and funct codes outside this subset (for example R-type ADD, funct 0x20) act as a NOP and only advance PC by 4.
- R12: Reset clears PC, every register, the halt flag, the window counter and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instrAddr | output | 32 | Byte address of the instruction being fetched (PC) |
| instrData | input | 32 | Instruction word at `instrAddr`, same cycle |
| memAddr | output | 30 | Word address of the data access |
| memWrData | output | 32 | Store data |
| memWe | output | 1 | Store strobe, written on the next rising edge |
| memRdData | input | 32 | Data word at `memAddr`, same cycle |
| cfgInterval | input | CNT_W | Window length C for updates of `done` |
| done | output | 1 | Halt status, refreshed once per window |

## Verification
An instruction's effects land on the rising edge that closes its own fetch cycle. A store reaches the bench memory on that edge, and a load feeds its register on that edge too. The bench therefore reads memory contents only after a run has settled, and it samples every port at falling edges. The bench records the edge count at which the halt word first appears on `instrAddr`. From that count it predicts the first edge on which `done` can rise: the first multiple of C that is at least two edges later. At every falling edge it compares `done` with that prediction and checks that PC and `memWe` stay frozen from the halt cycle onward.

// File: rtl/haltcore_pkg.sv
package haltcore_pkg;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } aluSel_t;

  typedef enum logic [2:0] {
    NX_SEQ, NX_BEQ, NX_BNE, NX_BLEZ, NX_BGTZ, NX_JUMP, NX_JREG
  } nextSel_t;

  typedef enum logic [1:0] { DST_RT, DST_RD, DST_RA } dstSel_t;
  typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wbSel_t;

  // strobes from control to datapath
  typedef struct packed {
    aluSel_t  aluSel;
    logic     useImm;
    logic     zeroExt;
    logic     regWe;
    dstSel_t  dstSel;
    wbSel_t   wbSel;
    logic     memWe;
    nextSel_t nextSel;
    logic     commit;
  } strobe_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_BLEZ  = 6'h06;
  localparam logic [5:0] OP_BGTZ  = 6'h07;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/haltCtrl.sv
module haltCtrl
  import haltcore_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      instr,
  input  logic             raZero,
  input  logic [CNT_W-1:0] cfgInterval,
  output strobe_t          strb,
  output logic             done
);

  localparam logic [31:0] HALT_SPIN = {OP_BEQ, 5'd0, 5'd0, 16'hFFFF};
  localparam logic [31:0] HALT_RET  = {OP_RTYPE, 5'd31, 15'd0, FN_JR};

  logic [5:0] op, funct;
  logic       haltNow, haltQ, wrap;
  logic [CNT_W-1:0] cntQ, lastIdx;

  assign op    = instr[31:26];
  assign funct = instr[5:0];

  // decode into strobes
  always_comb begin
    strb = '{aluSel: ALU_ADD, useImm: 1'b0, zeroExt: 1'b0, regWe: 1'b0,
             dstSel: DST_RT, wbSel: WB_ALU, memWe: 1'b0, nextSel: NX_SEQ,
             commit: 1'b0};
    case (op)
      OP_RTYPE: begin
        strb.dstSel = DST_RD;
        strb.regWe  = 1'b1;
        case (funct)
          FN_ADDU: strb.aluSel = ALU_ADD;
          FN_SUBU: strb.aluSel = ALU_SUB;
          FN_AND:  strb.aluSel = ALU_AND;
          FN_OR:   strb.aluSel = ALU_OR;
          FN_XOR:  strb.aluSel = ALU_XOR;
          FN_NOR:  strb.aluSel = ALU_NOR;
          FN_SLT:  strb.aluSel = ALU_SLT;
          FN_SLTU: strb.aluSel = ALU_SLTU;
          FN_SLL:  strb.aluSel = ALU_SLL;
          FN_SRL:  strb.aluSel = ALU_SRL;
          FN_SRA:  strb.aluSel = ALU_SRA;
          FN_JR: begin
            strb.regWe   = 1'b0;
            strb.nextSel = NX_JREG;
          end
          default: strb.regWe = 1'b0;  // unsupported: NOP
        endcase
      end
      OP_ADDIU: begin strb.useImm = 1'b1; strb.regWe = 1'b1; end
      OP_SLTIU: begin strb.useImm = 1'b1; strb.regWe = 1'b1; strb.aluSel = ALU_SLTU; end
      OP_ANDI:  begin strb.useImm = 1'b1; strb.zeroExt = 1'b1; strb.regWe = 1'b1; strb.aluSel = ALU_AND; end
      OP_ORI:   begin strb.useImm = 1'b1; strb.zeroExt = 1'b1; strb.regWe = 1'b1; strb.aluSel = ALU_OR; end
      OP_XORI:  begin strb.useImm = 1'b1; strb.zeroExt = 1'b1; strb.regWe = 1'b1; strb.aluSel = ALU_XOR; end
      OP_LUI:   begin strb.regWe = 1'b1; strb.aluSel = ALU_LUI; end
      OP_BEQ:   strb.nextSel = NX_BEQ;
      OP_BNE:   strb.nextSel = NX_BNE;
      OP_BLEZ:  strb.nextSel = NX_BLEZ;
      OP_BGTZ:  strb.nextSel = NX_BGTZ;
      OP_J:     strb.nextSel = NX_JUMP;
      OP_JAL: begin
        strb.nextSel = NX_JUMP;
        strb.regWe   = 1'b1;
        strb.dstSel  = DST_RA;
        strb.wbSel   = WB_LINK;
      end
      OP_LW: begin strb.useImm = 1'b1; strb.regWe = 1'b1; strb.wbSel = WB_MEM; end
      OP_SW: begin strb.useImm = 1'b1; strb.memWe = 1'b1; end
      default: ;
    endcase
    strb.commit = !(haltNow || haltQ);
  end

  // stop-pattern test on the fetched word
  assign haltNow = (instr == HALT_SPIN) || ((instr == HALT_RET) && raZero);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) haltQ <= 1'b0;
    else if (haltNow) haltQ <= 1'b1;
  end

  // window counter: done refreshed only when the window closes
  assign lastIdx = (cfgInterval == '0) ? '0 : cfgInterval - 1'b1;
  assign wrap    = (cntQ >= lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      done <= 1'b0;
    end else if (wrap) begin
      cntQ <= '0;
      done <= haltQ;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  p_sticky_halt_r9: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |=> haltQ);

  p_done_window_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(done));

  p_done_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(haltQ));

endmodule

// File: rtl/haltPath.sv
module haltPath
  import haltcore_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [25:0]   instrLow,
  input  strobe_t       strb,
  input  logic [DW-1:0] memRdData,
  output logic [DW-1:0] pcOut,
  output logic [DW-3:0] memAddr,
  output logic [DW-1:0] memWrData,
  output logic          memWe,
  output logic          raZero
);

  localparam int NREG = 32;
  localparam int IDX_W = $clog2(NREG);
  localparam int IMM_W = 16;

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] pcQ, pcNext, pcPlus4, brTarget, jTarget;
  logic [IDX_W-1:0] rsIdx, rtIdx, rdIdx, dstIdx;
  logic [4:0] shamt;
  logic [IMM_W-1:0] imm;
  logic [DW-1:0] rsVal, rtVal, immExt, opB, sum, aluRes, wbData;
  logic taken;

  assign rsIdx = instrLow[25:21];
  assign rtIdx = instrLow[20:16];
  assign rdIdx = instrLow[15:11];
  assign shamt = instrLow[10:6];
  assign imm   = instrLow[15:0];

  assign rsVal  = rf[rsIdx];
  assign rtVal  = rf[rtIdx];
  assign immExt = strb.zeroExt ? {{(DW-IMM_W){1'b0}}, imm}
                               : {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
  assign opB    = strb.useImm ? immExt : rtVal;
  assign sum    = rsVal + opB;

  always_comb begin
    case (strb.aluSel)
      ALU_ADD:  aluRes = sum;
      ALU_SUB:  aluRes = rsVal - opB;
      ALU_AND:  aluRes = rsVal & opB;
      ALU_OR:   aluRes = rsVal | opB;
      ALU_XOR:  aluRes = rsVal ^ opB;
      ALU_NOR:  aluRes = ~(rsVal | opB);
      ALU_SLT:  aluRes = {{(DW-1){1'b0}}, $signed(rsVal) < $signed(opB)};
      ALU_SLTU: aluRes = {{(DW-1){1'b0}}, rsVal < opB};
      ALU_SLL:  aluRes = rtVal << shamt;
      ALU_SRL:  aluRes = rtVal >> shamt;
      ALU_SRA:  aluRes = $unsigned($signed(rtVal) >>> shamt);
      ALU_LUI:  aluRes = {imm, {(DW-IMM_W){1'b0}}};
      default:  aluRes = sum;
    endcase
  end

  // next PC
  assign pcPlus4  = pcQ + 4;
  assign brTarget = pcPlus4 + {immExt[DW-3:0], 2'b00};
  assign jTarget  = {pcPlus4[DW-1:DW-4], instrLow, 2'b00};

  always_comb begin
    case (strb.nextSel)
      NX_BEQ:  taken = (rsVal == rtVal);
      NX_BNE:  taken = (rsVal != rtVal);
      NX_BLEZ: taken = ($signed(rsVal) <= 0);
      NX_BGTZ: taken = ($signed(rsVal) > 0);
      default: taken = 1'b0;
    endcase
    case (strb.nextSel)
      NX_JUMP: pcNext = jTarget;
      NX_JREG: pcNext = rsVal;
      default: pcNext = taken ? brTarget : pcPlus4;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else if (strb.commit) pcQ <= pcNext;
  end

  // writeback
  always_comb begin
    case (strb.dstSel)
      DST_RD:  dstIdx = rdIdx;
      DST_RA:  dstIdx = IDX_W'(NREG - 1);
      default: dstIdx = rtIdx;
    endcase
    case (strb.wbSel)
      WB_MEM:  wbData = memRdData;
      WB_LINK: wbData = pcPlus4;
      default: wbData = aluRes;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (strb.commit && strb.regWe && dstIdx != '0) begin
      rf[dstIdx] <= wbData;
    end
  end

  assign pcOut     = pcQ;
  assign memAddr   = sum[DW-1:2];
  assign memWrData = rtVal;
  assign memWe     = strb.memWe && strb.commit;
  assign raZero    = (rf[NREG-1] == '0);

  p_seq_pc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.nextSel == NX_SEQ) |=> (pcQ == $past(pcQ) + 4));

  p_frozen_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(pcQ));

  p_aligned_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (sum[1:0] == 2'b00));

  p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWe && dstIdx == '0) |=> (rf[0] == '0));

endmodule

// File: rtl/haltCore.sv
module haltCore
  import haltcore_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [DW-1:0]    instrAddr,
  input  logic [DW-1:0]    instrData,
  output logic [DW-3:0]    memAddr,
  output logic [DW-1:0]    memWrData,
  output logic             memWe,
  input  logic [DW-1:0]    memRdData,
  input  logic [CNT_W-1:0] cfgInterval,
  output logic             done
);

  strobe_t strb;
  logic    raZero;

  haltCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .instr(instrData), .raZero(raZero),
    .cfgInterval(cfgInterval), .strb(strb), .done(done)
  );

  haltPath #(.DW(DW)) uPath (
    .clk(clk), .rstN(rstN), .instrLow(instrData[25:0]), .strb(strb),
    .memRdData(memRdData), .pcOut(instrAddr), .memAddr(memAddr),
    .memWrData(memWrData), .memWe(memWe), .raZero(raZero)
  );

endmodule

// File: tb/sim_haltCore.sv
module sim_haltCore;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam logic [31:0] FILL = 32'hA5A5A5A5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] instrAddr, instrData, memWrData, memRdData;
  logic [29:0] memAddr;
  logic memWe, done;
  logic [7:0] cfgInterval = 8'd1;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int errors = 0;
  int checks = 0;

  always #(HALF) clk = ~clk;

  assign instrData = imem[instrAddr[7:2]];
  assign memRdData = dmem[memAddr[5:0]];
  always @(posedge clk) if (rstN && memWe) dmem[memAddr[5:0]] <= memWrData;

  haltCore u0 (
    .clk(clk), .rstN(rstN), .instrAddr(instrAddr), .instrData(instrData),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe),
    .memRdData(memRdData), .cfgInterval(cfgInterval), .done(done)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] encJ(int op, int idx);
    return {6'(op), 26'(idx)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] = FILL;
    end
  endtask

  int storeRegs [16] = '{5, 6, 7, 8, 9, 10, 12, 13, 14, 15, 16, 17, 18, 19, 20, 0};

  task automatic loadProgA();
    clearMem();
    imem[0]  = encI(9, 0, 1, 16'd5);
    imem[1]  = encI(9, 0, 2, 16'd0);
    imem[2]  = encI(9, 0, 3, 16'd16);
    imem[3]  = encR(2, 1, 2, 0, 'h21);
    imem[4]  = encI('h2B, 3, 2, 16'd0);
    imem[5]  = encI(9, 3, 3, 16'd4);
    imem[6]  = encI(9, 1, 1, 16'hFFFF);
    imem[7]  = encI(5, 1, 0, 16'hFFFB);
    imem[8]  = encI('h23, 0, 4, 16'd16);
    imem[9]  = encR(0, 4, 5, 0, 'h23);
    imem[10] = encR(0, 5, 6, 1, 'h03);
    imem[11] = encR(0, 5, 7, 28, 'h02);
    imem[12] = encR(0, 4, 8, 3, 'h00);
    imem[13] = encR(5, 4, 9, 0, 'h2A);
    imem[14] = encR(5, 4, 10, 0, 'h2B);
    imem[15] = encI('h0F, 0, 12, 16'h1234);
    imem[16] = encI('h0D, 12, 12, 16'h5678);
    imem[17] = encI('h0E, 12, 13, 16'h00FF);
    imem[18] = encI('h0C, 12, 14, 16'hF0F0);
    imem[19] = encR(12, 13, 15, 0, 'h27);
    imem[20] = encI('h0B, 5, 16, 16'hFFFF);
    imem[21] = encI(9, 0, 0, 16'd9);
    imem[22] = encR(4, 4, 20, 0, 'h20);
    imem[23] = encR(12, 13, 17, 0, 'h26);
    imem[24] = encR(12, 14, 18, 0, 'h24);
    imem[25] = encR(14, 7, 19, 0, 'h25);
    for (int i = 0; i < 16; i++) imem[26+i] = encI('h2B, 0, storeRegs[i], 16'(128 + 4*i));
    imem[42] = 32'h1000FFFF;
    imem[43] = encI('h2B, 0, 2, 16'd0);
  endtask

  task automatic loadProgB();
    clearMem();
    imem[0]  = encJ(3, 4);
    imem[1]  = encI('h2B, 0, 31, 16'h40);
    imem[2]  = encI(9, 0, 31, 16'd0);
    imem[3]  = 32'h03E00008;
    imem[4]  = encI(9, 0, 20, 16'd7);
    imem[5]  = encI('h2B, 0, 20, 16'h44);
    imem[6]  = encI(6, 20, 0, 16'd1);
    imem[7]  = encI('h2B, 0, 20, 16'h48);
    imem[8]  = encI(7, 20, 0, 16'd1);
    imem[9]  = encI('h2B, 0, 0, 16'h44);
    imem[10] = encJ(2, 12);
    imem[11] = encI('h2B, 0, 0, 16'h48);
    imem[12] = encI(4, 20, 20, 16'd1);
    imem[13] = encI('h2B, 0, 0, 16'h48);
    imem[14] = encI(5, 20, 20, 16'd1);
    imem[15] = encI('h2B, 0, 20, 16'h4C);
    imem[16] = 32'h03E00008;
  endtask

  // reset, run to halt, check done timing and the frozen state
  task automatic runProg(int haltWord, int cval);
    int e, tHalt, kExp, lim, bad, stray;
    logic expDone;
    lim = (cval == 0) ? 1 : cval;
    e = 0; tHalt = -1; kExp = -1; bad = 0; stray = 0;
    rstN = 1'b0;
    cfgInterval = 8'(cval);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R12 reset pc", instrAddr, 32'd0);
    check("R12 reset done", {31'd0, done}, 32'd0);
    for (int n = 0; n < 3000; n++) begin
      if (tHalt < 0 && instrAddr == 32'(haltWord * 4)) begin
        tHalt = e;
        kExp = ((e + 2 + lim - 1) / lim) * lim;
      end
      if (tHalt >= 0) begin
        expDone = (e >= kExp);
        if (done !== expDone) bad++;
        if (memWe !== 1'b0 || instrAddr !== 32'(haltWord * 4)) stray++;
      end else if (done !== 1'b0) begin
        bad++;
      end
      if (kExp >= 0 && e >= kExp + 3 * lim + 8) break;
      @(posedge clk);
      e++;
      @(negedge clk);
    end
    check("R8 halt pattern reached", {31'd0, tHalt >= 0}, 32'd1);
    check("R10 done window timing", 32'(bad), 32'd0);
    check("R9 frozen pc and no store after halt", 32'(stray), 32'd0);
  endtask

  task automatic checkProgA();
    logic [31:0] expA [16];
    string tagA [16];
    logic [31:0] s;
    expA = '{32'hFFFFFFFB, 32'hFFFFFFFD, 32'h0000000F, 32'd40, 32'd1, 32'd0,
             32'h12345678, 32'h12345687, 32'h00005070, 32'hEDCBA900, 32'd1,
             32'h000000FF, 32'h00005070, 32'h0000507F, 32'd0, 32'd0};
    tagA = '{"R6 R1 subu after lw", "R2 sra", "R2 srl", "R2 sll", "R3 slt",
             "R3 sltu", "R1 lui/ori", "R1 xori", "R1 andi", "R1 nor", "R3 sltiu",
             "R1 xor", "R1 and", "R1 or", "R11 unsupported add", "R7 zero reg"};
    s = 0;
    for (int k = 0; k < 5; k++) begin
      s = s + 32'(5 - k);
      check("R4 R6 loop sum store", dmem[4+k], s);
    end
    for (int i = 0; i < 16; i++) check(tagA[i], dmem[32+i], expA[i]);
    check("R9 store after halt word untouched", dmem[0], FILL);
    check("R6 unrelated word untouched", dmem[50], FILL);
  endtask

  initial begin
    loadProgA();
    runProg(42, 5);
    checkProgA();

    loadProgB();
    runProg(3, 3);
    check("R5 jal link value", dmem[16], 32'd4);
    check("R5 R4 j and bgtz skip", dmem[17], 32'd7);
    check("R4 blez not taken, j skip", dmem[18], 32'd7);
    check("R4 beq taken, bne not taken", dmem[19], 32'd7);
    check("R6 unrelated word untouched", dmem[20], FILL);

    loadProgA();
    runProg(42, 0);
    checkProgA();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule